// File: doc/BRIEF.md
# Mailbox Ownership Semaphore Arbiter

This block decides who may use each of three shared mailbox RAMs: an external host or the on-chip processor (the device). Each mailbox has a byte-wide semaphore register in host address space. Only its two low bits carry meaning. The host writes `01` to ask for a mailbox and reads the register back to learn the result. A readback of `01` means the host holds the mailbox, `11` means the device holds it, and `00` means it is free. The host gives a mailbox back by writing `00`. The device side has its own per-mailbox request and release strobes and a per-mailbox ownership status.

The block also sits between the host and the three mailbox RAM windows. A host read or write that falls inside a window reaches that RAM only while the host holds the matching semaphore. Otherwise the write is dropped and the read returns `0x00`. When the host gains a mailbox, the block sends a one-cycle grant event on the bit with the same index, for the interrupt logic.

Each semaphore is a four-state machine:
- **FREE**: code `00`.
- **HOST**: code `01`.
- **DEV**: code `11`.
- **DEV_HWAIT**: code `11`. The device owns the mailbox and a host request is pending.

The transitions are:
- **FREE→DEV** on a device request. If the host requested in the same cycle, the machine goes to DEV_HWAIT instead.
- **FREE→HOST** on a host request alone.
- **HOST→FREE** on a host write of `00`.
- **DEV→FREE** on a device release.
- **DEV→HOST** on a device release together with a host request.
- **DEV→DEV_HWAIT** on a host request.
- **DEV_HWAIT→HOST** on a device release.
- **DEV_HWAIT→DEV** on a host write of `00`, which cancels the pending request.
- **DEV_HWAIT→FREE** on a device release together with a host cancel.

Every entry into HOST fires the grant event.

Top module: `mbox_sema_arbiter`

## Requirements
- R1: After reset, all three semaphores read `0x00`, `dev_own` and `grant_evt` are zero, and no RAM is selected.
- R2: A host write with bits 1:0 = `01` to a free semaphore gives the host ownership. It pulses `grant_evt[i]` for exactly one cycle, where bit i is semaphore i.
- R3: Semaphore i is at host address 0x1C+i. A read returns `01` when the host owns it, `11` when the device owns it and `00` when it is free. Bits 7:2 read as 0, and only bits 1:0 of a write are decoded.
- R4: A device request to a free semaphore gives the device ownership (`dev_own[i]`=1, readback `11`). A device release returns it to free.
- R5: When the host and the device request a free semaphore in the same cycle, the device wins and the host request stays pending.
- R6: A host request while the device owns a semaphore stays pending. It is granted, with a `grant_evt` pulse, in the cycle the device releases.
- R7: A host write of `00` while the host owns a semaphore frees it.
- R8: A host write of `00` while the host does not own a semaphore cancels any pending host request and leaves device ownership unchanged.
- R9: While the host owns a semaphore, device requests and releases have no effect. Host writes of `10` or `11` have no effect in any state.
- R10: The RAM windows are 0x2000–0x200E (mailbox 0), 0x200F–0x23FF (mailbox 1) and 0x2400–0x27FF (mailbox 2). A host access inside a window the host owns selects that RAM with the offset from the window base. Read data is returned, with `host_rvalid`, one cycle after the read strobe.
- R11: A host access to a window the host does not own leaves the RAM unselected: the write is dropped and the read returns `0x00`. A read of any unmapped address also returns `0x00`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_addr | input | 16 | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid, one cycle after host_rd |
| dev_req | input | 3 | Device request strobe per semaphore |
| dev_rel | input | 3 | Device release strobe per semaphore |
| dev_own | output | 3 | Device currently owns semaphore i |
| grant_evt | output | 3 | One-cycle event when the host is granted semaphore i |
| mem_sel | output | 3 | RAM i selected for a host access |
| mem_we | output | 1 | Write enable for the selected RAM |
| mem_addr | output | 16 | Byte offset inside the selected window |
| mem_wdata | output | 8 | Write data for the selected RAM |
| mem_rdata | input | 24 | Registered read data of the three RAMs, RAM i in bits 8i+7:8i |

## Verification
A strobe on a semaphore changes its state at the next rising edge. `grant_evt` and `dev_own` show the new state in the cycle that follows that edge, so `grant_evt` is due exactly one edge after the request. A read of a semaphore or a window returns data one edge after `host_rd`. That data comes from a snapshot taken at that edge, or from the RAM output registered at the same edge. The bench drives every stimulus on a falling edge and samples results at the next falling edge, half a period after the one edge that produces them. The sweep runs every start state against every host code and device action on every semaphore, and checks each result at that point.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int MBOX_N = 3;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int CODE_W = 2;
    localparam int IDX_W  = (MBOX_N > 1) ? $clog2(MBOX_N) : 1;

    localparam logic [ADDR_W-1:0] SEMA_BASE = 16'h001C;
    localparam logic [ADDR_W-1:0] WIN_LO [MBOX_N] = '{16'h2000, 16'h200F, 16'h2400};
    localparam logic [ADDR_W-1:0] WIN_HI [MBOX_N] = '{16'h200E, 16'h23FF, 16'h27FF};

    localparam logic [CODE_W-1:0] CODE_FREE = 2'b00;
    localparam logic [CODE_W-1:0] CODE_HOST = 2'b01;
    localparam logic [CODE_W-1:0] CODE_DEV  = 2'b11;

    typedef enum logic [1:0] {
        SEM_FREE,
        SEM_HOST,
        SEM_DEV,
        SEM_DEV_HWAIT
    } sem_state_e;

    typedef enum logic [1:0] {
        RSRC_ZERO,
        RSRC_SEMA,
        RSRC_RAM
    } rsrc_e;
endpackage

// File: rtl/mbox_sema_fsm.sv
module mbox_sema_fsm
    import mbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_take,
    input  logic              host_drop,
    input  logic              dev_take,
    input  logic              dev_drop,
    output logic [CODE_W-1:0] code,
    output logic              host_own,
    output logic              dev_own,
    output logic              grant
);
    sem_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEM_FREE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEM_FREE: begin
                if (dev_take)       state_d = host_take ? SEM_DEV_HWAIT : SEM_DEV;
                else if (host_take) state_d = SEM_HOST;
            end
            SEM_HOST: begin
                if (host_drop) state_d = SEM_FREE;
            end
            SEM_DEV: begin
                if (dev_drop)       state_d = host_take ? SEM_HOST : SEM_FREE;
                else if (host_take) state_d = SEM_DEV_HWAIT;
            end
            SEM_DEV_HWAIT: begin
                if (dev_drop)       state_d = host_drop ? SEM_FREE : SEM_HOST;
                else if (host_drop) state_d = SEM_DEV;
            end
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) grant <= 1'b0;
        else        grant <= (state_d == SEM_HOST) && (state_q != SEM_HOST);
    end

    always_comb begin
        unique case (state_q)
            SEM_FREE:      code = CODE_FREE;
            SEM_HOST:      code = CODE_HOST;
            SEM_DEV,
            SEM_DEV_HWAIT: code = CODE_DEV;
        endcase
        host_own = (state_q == SEM_HOST);
        dev_own  = (state_q == SEM_DEV) || (state_q == SEM_DEV_HWAIT);
    end
endmodule

// File: rtl/mbox_host_decode.sv
module mbox_host_decode
    import mbox_pkg::*;
(
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [MBOX_N-1:0] host_own,
    output logic [MBOX_N-1:0] sema_take,
    output logic [MBOX_N-1:0] sema_drop,
    output logic [MBOX_N-1:0] mem_sel,
    output logic [ADDR_W-1:0] mem_addr,
    output rsrc_e             rd_src,
    output logic [IDX_W-1:0]  rd_idx
);
    logic [MBOX_N-1:0] sema_hit;
    logic [MBOX_N-1:0] win_hit;
    logic              access;

    assign access = host_wr | host_rd;

    for (genvar g = 0; g < MBOX_N; g++) begin : g_mbox
        assign sema_hit[g]  = (host_addr == SEMA_BASE + ADDR_W'(g));
        assign win_hit[g]   = (host_addr >= WIN_LO[g]) && (host_addr <= WIN_HI[g]);
        assign sema_take[g] = host_wr && sema_hit[g] && (host_wdata[CODE_W-1:0] == CODE_HOST);
        assign sema_drop[g] = host_wr && sema_hit[g] && (host_wdata[CODE_W-1:0] == CODE_FREE);
        assign mem_sel[g]   = access && win_hit[g] && host_own[g];
    end

    always_comb begin
        mem_addr = '0;
        rd_src   = RSRC_ZERO;
        rd_idx   = '0;
        for (int i = 0; i < MBOX_N; i++) begin
            if (win_hit[i]) mem_addr = host_addr - WIN_LO[i];
            if (sema_hit[i]) begin
                rd_src = RSRC_SEMA;
                rd_idx = IDX_W'(i);
            end else if (win_hit[i] && host_own[i]) begin
                rd_src = RSRC_RAM;
                rd_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/mbox_rd_return.sv
module mbox_rd_return
    import mbox_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           host_rd,
    input  rsrc_e                          rd_src,
    input  logic [IDX_W-1:0]               rd_idx,
    input  logic [MBOX_N-1:0][CODE_W-1:0]  sema_code,
    input  logic [MBOX_N-1:0][DATA_W-1:0]  mem_rdata,
    output logic [DATA_W-1:0]              host_rdata,
    output logic                           host_rvalid
);
    rsrc_e              src_q;
    logic [IDX_W-1:0]   idx_q;
    logic [CODE_W-1:0]  code_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q       <= RSRC_ZERO;
            idx_q       <= '0;
            code_q      <= CODE_FREE;
            host_rvalid <= 1'b0;
        end else begin
            host_rvalid <= host_rd;
            if (host_rd) begin
                src_q  <= rd_src;
                idx_q  <= rd_idx;
                code_q <= sema_code[rd_idx];
            end
        end
    end

    always_comb begin
        unique case (src_q)
            RSRC_SEMA: host_rdata = {{(DATA_W-CODE_W){1'b0}}, code_q};
            RSRC_RAM:  host_rdata = mem_rdata[idx_q];
            default:   host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mbox_sema_arbiter.sv
module mbox_sema_arbiter
    import mbox_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     host_wr,
    input  logic                     host_rd,
    input  logic [ADDR_W-1:0]        host_addr,
    input  logic [DATA_W-1:0]        host_wdata,
    output logic [DATA_W-1:0]        host_rdata,
    output logic                     host_rvalid,
    input  logic [MBOX_N-1:0]        dev_req,
    input  logic [MBOX_N-1:0]        dev_rel,
    output logic [MBOX_N-1:0]        dev_own,
    output logic [MBOX_N-1:0]        grant_evt,
    output logic [MBOX_N-1:0]        mem_sel,
    output logic                     mem_we,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [DATA_W-1:0]        mem_wdata,
    input  logic [MBOX_N*DATA_W-1:0] mem_rdata
);
    logic [MBOX_N-1:0]              host_own;
    logic [MBOX_N-1:0]              sema_take;
    logic [MBOX_N-1:0]              sema_drop;
    logic [MBOX_N-1:0][CODE_W-1:0]  sema_code;
    logic [MBOX_N-1:0][DATA_W-1:0]  ram_rd;
    rsrc_e                          rd_src;
    logic [IDX_W-1:0]               rd_idx;

    assign mem_we    = host_wr;
    assign mem_wdata = host_wdata;
    assign ram_rd    = mem_rdata;

    mbox_host_decode u_decode (
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_own   (host_own),
        .sema_take  (sema_take),
        .sema_drop  (sema_drop),
        .mem_sel    (mem_sel),
        .mem_addr   (mem_addr),
        .rd_src     (rd_src),
        .rd_idx     (rd_idx)
    );

    for (genvar g = 0; g < MBOX_N; g++) begin : g_sema
        mbox_sema_fsm u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .host_take (sema_take[g]),
            .host_drop (sema_drop[g]),
            .dev_take  (dev_req[g]),
            .dev_drop  (dev_rel[g]),
            .code      (sema_code[g]),
            .host_own  (host_own[g]),
            .dev_own   (dev_own[g]),
            .grant     (grant_evt[g])
        );
    end

    mbox_rd_return u_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_rd     (host_rd),
        .rd_src      (rd_src),
        .rd_idx      (rd_idx),
        .sema_code   (sema_code),
        .mem_rdata   (ram_rd),
        .host_rdata  (host_rdata),
        .host_rvalid (host_rvalid)
    );
endmodule

// File: rtl/mbox_sema_arbiter_chk.sv
module mbox_sema_arbiter_chk
    import mbox_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic [MBOX_N-1:0] dev_rel,
    input logic [MBOX_N-1:0] host_own,
    input logic [MBOX_N-1:0] dev_own,
    input logic [MBOX_N-1:0] grant_evt,
    input logic [MBOX_N-1:0] mem_sel
);
    // R4: never held by both sides at once
    p_own_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_own & dev_own) == '0);

    // R2: a grant event marks exactly the cycles where host ownership begins
    p_grant_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_own & ~$past(host_own)) == grant_evt);

    // R2: a grant event never lasts two cycles
    p_grant_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_evt & $past(grant_evt)) == '0);

    // R9: device ownership only ends after a device release
    p_dev_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dev_own) & ~dev_own & ~$past(dev_rel)) == '0);

    // R7: host ownership only ends after a host write
    p_host_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(host_own) & ~host_own) != '0) |-> $past(host_wr));

    // R10: at most one RAM selected per access
    p_sel_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mem_sel));
endmodule

bind mbox_sema_arbiter mbox_sema_arbiter_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_wr   (host_wr),
    .dev_rel   (dev_rel),
    .host_own  (host_own),
    .dev_own   (dev_own),
    .grant_evt (grant_evt),
    .mem_sel   (mem_sel)
);

// File: tb/mbox_sema_arbiter_tb.sv
module mbox_sema_arbiter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [15:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        host_rvalid;
    logic [2:0]  dev_req = '0;
    logic [2:0]  dev_rel = '0;
    logic [2:0]  dev_own;
    logic [2:0]  grant_evt;
    logic [2:0]  mem_sel;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [23:0] mem_rdata;
    logic [7:0]  rdq [3];
    logic [7:0]  ram [3][1024];

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    mbox_sema_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid), .dev_req(dev_req), .dev_rel(dev_rel),
        .dev_own(dev_own), .grant_evt(grant_evt), .mem_sel(mem_sel),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    assign mem_rdata = {rdq[2], rdq[1], rdq[0]};

    always @(posedge clk) begin
        for (int k = 0; k < 3; k++) begin
            if (mem_sel[k]) begin
                if (mem_we) ram[k][mem_addr[9:0]] <= mem_wdata;
                else        rdq[k] <= ram[k][mem_addr[9:0]];
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic op(input int i, input int hop, input int dop);
        host_wr    = (hop != 0);
        host_addr  = 16'h001C + 16'(i);
        host_wdata = (hop != 0) ? 8'(hop - 1) : 8'h00;
        dev_req    = (dop == 1) ? 3'(1 << i) : 3'b000;
        dev_rel    = (dop == 2) ? 3'(1 << i) : 3'b000;
        @(negedge clk);
        host_wr = 1'b0; dev_req = '0; dev_rel = '0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    // states: 0 free, 1 host, 2 device, 3 device with host pending
    function automatic int ref_next(input int s, input int hop, input int dop, output bit g);
        bit h01, h00;
        int n;
        h01 = (hop == 2);
        h00 = (hop == 1);
        n = s;
        case (s)
            0: if (dop == 1) n = h01 ? 3 : 2; else if (h01) n = 1;
            1: if (h00) n = 0;
            2: if (dop == 2) n = h01 ? 1 : 0; else if (h01) n = 3;
            default: if (dop == 2) n = h00 ? 0 : 1; else if (h00) n = 2;
        endcase
        g = (n == 1) && (s != 1);
        return n;
    endfunction

    function automatic string tag_of(input int s, input int hop, input int dop);
        if (hop == 3 || hop == 4)         return "R9 host code 10/11";
        if (s == 1 && dop != 0)           return "R9 device during host";
        if (s == 1 && hop == 1)           return "R7 host release";
        if (s >= 2 && hop == 1)           return "R8 cancel";
        if (s == 0 && dop == 1 && hop == 2) return "R5 tie";
        if (s >= 2)                       return "R6 pending";
        if (s == 0 && hop == 2)           return "R2 grant";
        if (dop != 0)                     return "R4 device";
        return "R3 readback";
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int ns;
        bit g;
        logic [15:0] a;
        for (int k = 0; k < 3; k++)
            for (int x = 0; x < 1024; x++) ram[k][x] = 8'(k * 16 + x);
        for (int k = 0; k < 3; k++) rdq[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 dev_own", {5'b0, dev_own}, 8'h00);
        chk("R1 grant", {5'b0, grant_evt}, 8'h00);
        chk("R1 mem_sel", {5'b0, mem_sel}, 8'h00);
        for (int i = 0; i < 3; i++) begin
            rd(16'h001C + 16'(i), d);
            chk("R1 sema code", d, 8'h00);
        end

        // R3 reserved bits: write 0xFD acts as 01, then 0xFC acts as 00
        wr(16'h001C, 8'hFD);
        rd(16'h001C, d);
        chk("R3 upper bits ignored on take", d, 8'h01);
        wr(16'h001C, 8'hFC);
        rd(16'h001C, d);
        chk("R3 upper bits ignored on release", d, 8'h00);

        // sweep every start state x host code x device action per semaphore
        for (int i = 0; i < 3; i++)
            for (int s = 0; s < 4; s++)
                for (int hop = 0; hop < 5; hop++)
                    for (int dop = 0; dop < 3; dop++) begin
                        op(i, 1, 2);
                        if (s == 1) op(i, 2, 0);
                        if (s == 2) op(i, 0, 1);
                        if (s == 3) begin op(i, 0, 1); op(i, 2, 0); end
                        ns = ref_next(s, hop, dop, g);
                        op(i, hop, dop);
                        chk(tag_of(s, hop, dop), {5'b0, grant_evt}, g ? 8'(1 << i) : 8'h00);
                        chk(tag_of(s, hop, dop), {7'b0, dev_own[i]}, (ns >= 2) ? 8'h01 : 8'h00);
                        rd(16'h001C + 16'(i), d);
                        chk(tag_of(s, hop, dop), d, (ns == 0) ? 8'h00 : (ns == 1) ? 8'h01 : 8'h03);
                    end

        // windows
        for (int i = 0; i < 3; i++) begin
            a = (i == 0) ? 16'h2005 : (i == 1) ? 16'h2014 : 16'h2405;
            op(i, 1, 2);
            wr(a, 8'hA5);
            rd(a, d);
            chk("R11 blocked read while free", d, 8'h00);
            op(i, 0, 1);
            rd(a, d);
            chk("R11 blocked read while device owns", d, 8'h00);
            op(i, 0, 2);
            op(i, 2, 0);
            rd(a, d);
            chk("R11 blocked write dropped", d, 8'(i * 16 + 5));
            chk("R10 rvalid", {7'b0, host_rvalid}, 8'h01);
            wr(a, 8'h5A ^ 8'(i));
            rd(a, d);
            chk("R10 owned write/read", d, 8'h5A ^ 8'(i));
            wr((i == 0) ? 16'h200E : (i == 1) ? 16'h23FF : 16'h27FF, 8'hC0 + 8'(i));
            rd((i == 0) ? 16'h200E : (i == 1) ? 16'h23FF : 16'h27FF, d);
            chk("R10 window top byte", d, 8'hC0 + 8'(i));
            op(i, 1, 0);
            rd(a, d);
            chk("R11 blocked after release", d, 8'h00);
        end
        // window 0 owned does not open window 1 (boundary 0x200F)
        op(0, 2, 0);
        op(1, 1, 2);
        rd(16'h200F, d);
        chk("R11 neighbour window boundary", d, 8'h00);
        rd(16'h200E, d);
        chk("R10 window 0 top byte kept", d, 8'hC0);
        op(0, 1, 0);
        rd(16'h001F, d);
        chk("R11 unmapped register", d, 8'h00);
        rd(16'h2800, d);
        chk("R11 beyond last window", d, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule